// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block runs one transaction at a time against a 16-bit-word serial EEPROM on a three-wire bus with a separate select line. A command port supplies a 3-bit operation code, an 8-bit word address and a 16-bit word. A one-cycle start strobe launches the transaction. The controller builds the serial frame, makes the serial clock from the system clock, and returns the read word, a one-cycle completion pulse and a timeout flag.

The serial clock high time, the serial clock low time and the minimum select-low interval are parameters counted in system clock cycles. New bits are driven while the serial clock is low. The returned line is sampled in the last low cycle before each rising serial clock edge. After every programming command the controller drops select and waits out the low interval. It then raises select again and watches the returned line for the ready level. A poll counter bounds this wait and ends a transaction whose device never reports ready.

Top module: `mw_host`

## Requirements
- R1: While reset is asserted, and right after it, `mw_cs`, `mw_sk`, `cmd_done` and `cmd_timeout` are all 0.
- R2: Every frame starts with a 1, followed by a 2-bit device opcode and 8 address bits, all most significant bit first. Write-type commands add 16 data bits after the address. The `cmd_op` codes are 0 read (device opcode 10), 1 write (01, with data) and 2 erase (11). Bits are shifted on rising `mw_sk` while `mw_cs` is high.
- R3: For the global commands the device opcode is 00 and the top two address bits select the command. Code 5 is enable programming (11), code 3 is erase all (10), code 4 is write all (01, with data) and code 6 is disable programming (00). The other six address bits are 0.
- R4: Each `mw_sk` high phase lasts at least SK_HI cycles. Each low phase that ends in a rising edge while `mw_cs` is high lasts at least SK_LO cycles.
- R5: `mw_sk` is 0 in every cycle where `mw_cs` rises or falls.
- R6: A read clocks 17 further cells after the address. The first sampled bit is the dummy and is dropped. The following 16 bits form `cmd_rdata`, most significant bit first.
- R7: After the last bit of a programming command (codes 1 to 4), `mw_cs` goes low, stays low for CS_LO cycles, and then goes high with `mw_sk` still low. `cmd_done` is not raised until `mw_do` has been seen at 1 during this poll.
- R8: Each rising edge of `mw_cs` comes after at least CS_LO cycles of `mw_cs` low.
- R9: If `mw_do` stays 0 for POLL_MAX poll cycles, the transaction ends with `cmd_done` and `cmd_timeout` set to 1. `cmd_timeout` stays set until the next accepted start, which clears it.
- R10: `cmd_start` is acted on only while the controller is idle. A strobe during a transaction produces no extra frame.
- R11: A start carrying `cmd_op` code 7 is ignored, and `mw_cs` stays low.
- R12: `cmd_done` is high for exactly one cycle per transaction. That cycle is the cycle in which `mw_cs` falls for the last time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle strobe launching a transaction |
| cmd_op | input | 3 | Operation code (see R2, R3, R11) |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Word for write and write-all |
| cmd_rdata | output | 16 | Word returned by the last read |
| cmd_done | output | 1 | Transaction finished (one cycle) |
| cmd_timeout | output | 1 | Last poll ran out of time |
| mw_cs | output | 1 | Device select |
| mw_sk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data toward the device |
| mw_do | input | 1 | Serial data and ready status from the device |

## Verification
The hardest case to reach from the ports is the poll timeout, because a well-behaved device always turns ready. The bench's device model has a switch that holds the status line at busy, and an erase is issued while it is set. The bench then checks that completion arrives with the timeout flag raised. The next transaction must clear the flag and read back the erased word. A second hard case is a start strobe arriving during a read. The bench injects one mid-frame, and the scoreboard rejects any frame it was not told to expect.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int HDR_W    = 1 + 2 + ADDR_W;
  localparam int FRAME_W  = HDR_W + DATA_W;
  localparam int RX_CELLS = DATA_W + 1;
  localparam int IDX_W    = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_WRITE_ALL = 3'd4,
    OP_PROG_EN   = 3'd5,
    OP_PROG_DIS  = 3'd6,
    OP_NONE      = 3'd7
  } mw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TX   = 3'd1,
    ST_RX   = 3'd2,
    ST_PGAP = 3'd3,
    ST_POLL = 3'd4,
    ST_GAP  = 3'd5
  } mw_state_e;
endpackage

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_pkg::*;
(
  input  logic [2:0]          op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [FRAME_W-1:0]  frame,
  output logic [IDX_W-1:0]    nbits,
  output logic                is_read,
  output logic                is_prog,
  output logic                valid
);
  localparam int PAD_W = ADDR_W - 2;

  logic [1:0]        opc;
  logic [ADDR_W-1:0] a_fld;
  logic              has_data;

  always_comb begin
    opc      = 2'b00;
    a_fld    = addr;
    has_data = 1'b0;
    is_read  = 1'b0;
    is_prog  = 1'b0;
    valid    = 1'b1;
    case (mw_op_e'(op))
      OP_READ: begin
        opc     = 2'b10;
        is_read = 1'b1;
      end
      OP_WRITE: begin
        opc      = 2'b01;
        has_data = 1'b1;
        is_prog  = 1'b1;
      end
      OP_ERASE: begin
        opc     = 2'b11;
        is_prog = 1'b1;
      end
      OP_ERASE_ALL: begin
        a_fld   = {2'b10, {PAD_W{1'b0}}};
        is_prog = 1'b1;
      end
      OP_WRITE_ALL: begin
        a_fld    = {2'b01, {PAD_W{1'b0}}};
        has_data = 1'b1;
        is_prog  = 1'b1;
      end
      OP_PROG_EN:  a_fld = {2'b11, {PAD_W{1'b0}}};
      OP_PROG_DIS: a_fld = {2'b00, {PAD_W{1'b0}}};
      default: begin
        valid = 1'b0;
      end
    endcase
    frame = {1'b1, opc, a_fld, (has_data ? wdata : {DATA_W{1'b0}})};
    nbits = has_data ? IDX_W'(FRAME_W) : IDX_W'(HDR_W);
  end
endmodule

// File: rtl/mw_bit_timer.sv
module mw_bit_timer #(
  parameter int SK_HI = 2,
  parameter int SK_LO = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_hi,
  output logic sample_now,
  output logic cell_end
);
  localparam int MAXP = (SK_HI > SK_LO) ? SK_HI : SK_LO;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          hi_q, hi_nx;
  logic          last_lo, last_hi;

  assign last_lo    = !hi_q && (cnt_q == CW'(SK_LO - 1));
  assign last_hi    =  hi_q && (cnt_q == CW'(SK_HI - 1));
  assign phase_hi   = hi_q;
  assign sample_now = run && last_lo;
  assign cell_end   = run && last_hi;

  always_comb begin
    cnt_nx = cnt_q + CW'(1);
    hi_nx  = hi_q;
    if (!run) begin
      cnt_nx = '0;
      hi_nx  = 1'b0;
    end else if (last_lo) begin
      cnt_nx = '0;
      hi_nx  = 1'b1;
    end else if (last_hi) begin
      cnt_nx = '0;
      hi_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      hi_q  <= hi_nx;
    end
  end

  // phase length monitors, saturating
  logic [CW-1:0] hi_run_q, lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      if (run && hi_q)
        hi_run_q <= (hi_run_q == CW'(SK_HI)) ? hi_run_q : hi_run_q + CW'(1);
      else
        hi_run_q <= '0;
      if (run && !hi_q)
        lo_run_q <= (lo_run_q == CW'(SK_LO)) ? lo_run_q : lo_run_q + CW'(1);
      else
        lo_run_q <= '0;
    end
  end

  // R4
  sk_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_q) |-> hi_run_q == CW'(SK_HI));
  // R4
  sk_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> lo_run_q == CW'(SK_LO));
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (clr)           q_nx = '0;
    else if (shift_en) q_nx = {q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/mw_host.sv
module mw_host
  import mw_pkg::*;
#(
  parameter int SK_HI    = 2,
  parameter int SK_LO    = 2,
  parameter int CS_LO    = 4,
  parameter int POLL_MAX = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [15:0]       cmd_wdata,
  output logic [15:0]       cmd_rdata,
  output logic              cmd_done,
  output logic              cmd_timeout,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int GAP_W  = $clog2(CS_LO + 1);
  localparam int POLL_W = $clog2(POLL_MAX + 1);

  mw_state_e          st_q, st_nx;
  logic [FRAME_W-1:0] frame_q, frame_nx;
  logic [IDX_W-1:0]   nbits_q, nbits_nx;
  logic [IDX_W-1:0]   idx_q, idx_nx;
  logic               rd_q, rd_nx;
  logic               pg_q, pg_nx;
  logic [GAP_W-1:0]   gap_q, gap_nx;
  logic [POLL_W-1:0]  poll_q, poll_nx;
  logic [DATA_W-1:0]  rdata_q, rdata_nx;
  logic               done_q, done_nx;
  logic               tout_q, tout_nx;

  logic [FRAME_W-1:0] fb_frame;
  logic [IDX_W-1:0]   fb_nbits;
  logic               fb_read, fb_prog, fb_valid;
  logic               run, phase_hi, sample_now, cell_end;
  logic               rx_clr, rx_shift;
  logic [DATA_W-1:0]  rx_q;

  mw_frame_build u_fb (
    .op      (cmd_op),
    .addr    (cmd_addr),
    .wdata   (cmd_wdata),
    .frame   (fb_frame),
    .nbits   (fb_nbits),
    .is_read (fb_read),
    .is_prog (fb_prog),
    .valid   (fb_valid)
  );

  assign run = (st_q == ST_TX) || (st_q == ST_RX);

  mw_bit_timer #(.SK_HI(SK_HI), .SK_LO(SK_LO)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .phase_hi   (phase_hi),
    .sample_now (sample_now),
    .cell_end   (cell_end)
  );

  mw_rx_shift #(.W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rx_clr),
    .shift_en (rx_shift),
    .din      (mw_do),
    .q        (rx_q)
  );

  always_comb begin
    st_nx    = st_q;
    frame_nx = frame_q;
    nbits_nx = nbits_q;
    idx_nx   = idx_q;
    rd_nx    = rd_q;
    pg_nx    = pg_q;
    gap_nx   = gap_q;
    poll_nx  = poll_q;
    rdata_nx = rdata_q;
    done_nx  = 1'b0;
    tout_nx  = tout_q;
    rx_clr   = 1'b0;
    rx_shift = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_start && fb_valid) begin
          st_nx    = ST_TX;
          frame_nx = fb_frame;
          nbits_nx = fb_nbits;
          idx_nx   = '0;
          rd_nx    = fb_read;
          pg_nx    = fb_prog;
          tout_nx  = 1'b0;
          rx_clr   = 1'b1;
        end
      end
      ST_TX: begin
        if (cell_end) begin
          if (idx_q == nbits_q - IDX_W'(1)) begin
            idx_nx = '0;
            gap_nx = '0;
            if (rd_q) begin
              st_nx = ST_RX;
            end else if (pg_q) begin
              st_nx = ST_PGAP;
            end else begin
              st_nx   = ST_GAP;
              done_nx = 1'b1;
            end
          end else begin
            idx_nx   = idx_q + IDX_W'(1);
            frame_nx = {frame_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
      ST_RX: begin
        // the first cell carries the dummy bit and is not shifted in
        rx_shift = sample_now && (idx_q != '0);
        if (cell_end) begin
          if (idx_q == IDX_W'(RX_CELLS - 1)) begin
            st_nx    = ST_GAP;
            gap_nx   = '0;
            done_nx  = 1'b1;
            rdata_nx = rx_q;
          end else begin
            idx_nx = idx_q + IDX_W'(1);
          end
        end
      end
      ST_PGAP: begin
        gap_nx = gap_q + GAP_W'(1);
        if (gap_q == GAP_W'(CS_LO - 1)) begin
          st_nx   = ST_POLL;
          poll_nx = '0;
        end
      end
      ST_POLL: begin
        poll_nx = poll_q + POLL_W'(1);
        if (mw_do) begin
          st_nx   = ST_GAP;
          gap_nx  = '0;
          done_nx = 1'b1;
        end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
          st_nx   = ST_GAP;
          gap_nx  = '0;
          done_nx = 1'b1;
          tout_nx = 1'b1;
        end
      end
      ST_GAP: begin
        gap_nx = gap_q + GAP_W'(1);
        if (gap_q == GAP_W'(CS_LO - 1)) st_nx = ST_IDLE;
      end
      default: st_nx = ST_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_GAP;
      frame_q <= '0;
      nbits_q <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      pg_q    <= 1'b0;
      gap_q   <= '0;
      poll_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      st_q    <= st_nx;
      frame_q <= frame_nx;
      nbits_q <= nbits_nx;
      idx_q   <= idx_nx;
      rd_q    <= rd_nx;
      pg_q    <= pg_nx;
      gap_q   <= gap_nx;
      poll_q  <= poll_nx;
      rdata_q <= rdata_nx;
      done_q  <= done_nx;
      tout_q  <= tout_nx;
    end
  end

  assign mw_cs       = (st_q == ST_TX) || (st_q == ST_RX) || (st_q == ST_POLL);
  assign mw_sk       = run && phase_hi;
  assign mw_di       = (st_q == ST_TX) && frame_q[FRAME_W-1];
  assign cmd_rdata   = rdata_q;
  assign cmd_done    = done_q;
  assign cmd_timeout = tout_q;

  // select-low interval monitor, saturating
  logic [GAP_W-1:0] cs_lo_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cs_lo_run_q <= '0;
    else if (mw_cs) cs_lo_run_q <= '0;
    else if (cs_lo_run_q != GAP_W'(CS_LO)) cs_lo_run_q <= cs_lo_run_q + GAP_W'(1);
  end

  // R5
  sk_low_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> !mw_sk);
  // R5
  sk_low_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_cs) |-> !mw_sk);
  // R8
  cs_low_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> cs_lo_run_q == GAP_W'(CS_LO));
  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  // R12
  done_at_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $fell(mw_cs));
  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_timeout) |-> cmd_done);
  // R7
  ready_ends_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POLL) && mw_do |=> cmd_done && !cmd_timeout);
  // R11
  null_op_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && cmd_start && (cmd_op == 3'd7) |=> !mw_cs);
endmodule

// File: tb/test_mw_host.sv
module test_mw_host;
  localparam int SK_HI    = 3;
  localparam int SK_LO    = 2;
  localparam int CS_LO    = 5;
  localparam int POLL_MAX = 300;
  localparam int BUSY_CYC = 60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        cmd_start;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic [15:0] cmd_rdata;
  logic        cmd_done, cmd_timeout;
  logic        mw_cs, mw_sk, mw_di, mw_do;

  mw_host #(.SK_HI(SK_HI), .SK_LO(SK_LO), .CS_LO(CS_LO), .POLL_MAX(POLL_MAX)) i_mw_host (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .cmd_done(cmd_done), .cmd_timeout(cmd_timeout),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct { logic [27:0] bits; int len; } frame_t;
  frame_t exp_q[$];

  // expected serial frame from R2/R3
  function automatic frame_t want(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    frame_t f;
    case (op)
      3'd0: begin f.bits = {1'b1, 2'b10, a, 17'b0}; f.len = 28; end
      3'd1: begin f.bits = {1'b0, 1'b1, 2'b01, a, d}; f.len = 27; end
      3'd2: begin f.bits = {17'b0, 1'b1, 2'b11, a}; f.len = 11; end
      3'd3: begin f.bits = {17'b0, 1'b1, 2'b00, 8'h80}; f.len = 11; end
      3'd4: begin f.bits = {1'b0, 1'b1, 2'b00, 8'h40, d}; f.len = 27; end
      3'd5: begin f.bits = {17'b0, 1'b1, 2'b00, 8'hC0}; f.len = 11; end
      default: begin f.bits = {17'b0, 1'b1, 2'b00, 8'h00}; f.len = 11; end
    endcase
    return f;
  endfunction

  // device model
  logic [15:0] mem [256] = '{default: 16'h0000};
  logic [27:0] cap = '0;
  int          m_cnt = 0;
  bit          wen = 0, reading = 0, stuck = 0, cs_prev = 0;
  logic        rd_bit = 1'b0;
  logic [15:0] rd_word = '0;
  int          busy_until = 0;

  assign mw_do = !mw_cs ? 1'b0 : reading ? rd_bit : stuck ? 1'b0 : (cyc >= busy_until);

  always @(posedge mw_sk or mw_cs) begin
    if (mw_cs !== cs_prev) begin
      cs_prev = mw_cs;
      if (mw_cs) begin
        m_cnt = 0; cap = '0; reading = 0;
      end else if (m_cnt > 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected frame", 32'(cap), 32'h0);
        end else begin
          frame_t e;
          e = exp_q.pop_front();
          chk(cap == e.bits && m_cnt == e.len, "R2/R3 frame", 32'(cap), 32'(e.bits));
        end
        if (m_cnt == 11) begin
          if (cap[9:8] == 2'b00) begin
            case (cap[7:6])
              2'b11: wen = 1;
              2'b00: wen = 0;
              2'b10: if (wen) begin
                for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
                busy_until = cyc + BUSY_CYC;
              end
              default: ;
            endcase
          end else if (cap[9:8] == 2'b11 && wen) begin
            mem[cap[7:0]] = 16'hFFFF;
            busy_until = cyc + BUSY_CYC;
          end
        end else if (m_cnt == 27 && wen) begin
          if (cap[25:24] == 2'b01) begin
            mem[cap[23:16]] = cap[15:0];
            busy_until = cyc + BUSY_CYC;
          end else if (cap[25:24] == 2'b00 && cap[23:22] == 2'b01) begin
            for (int i = 0; i < 256; i++) mem[i] = cap[15:0];
            busy_until = cyc + BUSY_CYC;
          end
        end
        reading = 0;
      end
    end else if (mw_sk && mw_cs) begin
      cap = {cap[26:0], mw_di};
      m_cnt++;
      if (m_cnt == 11 && cap[10] && cap[9:8] == 2'b10) begin
        reading = 1; rd_word = mem[cap[7:0]]; rd_bit = 1'b0;
      end else if (reading && m_cnt >= 12 && m_cnt <= 27) begin
        rd_bit = rd_word[27 - m_cnt];
      end
    end
  end

  // pin timing monitor: R4, R5, R8, R12
  bit p_cs = 0, p_sk = 0, p_done = 0;
  int hi_run = 0, lo_run = 0, cs_lo = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mw_sk && !p_sk) begin chk(lo_run >= SK_LO, "R4 sk low", 32'(lo_run), 32'(SK_LO)); lo_run = 0; end
      if (!mw_sk && p_sk) begin chk(hi_run >= SK_HI, "R4 sk high", 32'(hi_run), 32'(SK_HI)); hi_run = 0; end
      if (mw_sk) hi_run++; else if (mw_cs) lo_run++; else lo_run = 0;
      if (mw_cs && !p_cs) begin
        chk(!mw_sk, "R5 sk at cs rise", 32'(mw_sk), 32'h0);
        chk(cs_lo >= CS_LO, "R8 cs low time", 32'(cs_lo), 32'(CS_LO));
      end
      if (!mw_cs && p_cs) chk(!mw_sk, "R5 sk at cs fall", 32'(mw_sk), 32'h0);
      if (!mw_cs) cs_lo++; else cs_lo = 0;
      if (cmd_done) begin
        chk(!p_done, "R12 done width", 32'(p_done), 32'h0);
        chk(p_cs && !mw_cs, "R12 done with cs fall", {30'b0, p_cs, mw_cs}, 32'h2);
      end
    end
    p_cs = mw_cs; p_sk = mw_sk; p_done = cmd_done;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [15:0] r_data;
  bit          r_tout;
  int          r_cyc;

  task automatic wait_done();
    int n = 0;
    while (!cmd_done && n < 5000) begin @(negedge clk); n++; end
    chk(cmd_done, "R12 done seen", 32'(cmd_done), 32'h1);
    r_data = cmd_rdata; r_tout = cmd_timeout; r_cyc = cyc;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    exp_q.push_back(want(op, a, d));
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_done();
    repeat (CS_LO + 3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
    repeat (4) @(negedge clk);
    // R1
    chk(!mw_cs && !mw_sk && !cmd_done && !cmd_timeout, "R1 reset outputs",
        {28'b0, mw_cs, mw_sk, cmd_done, cmd_timeout}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mw_cs && !cmd_done, "R1 after release", {30'b0, mw_cs, cmd_done}, 32'h0);
    repeat (CS_LO + 3) @(negedge clk);

    run_cmd(3'd5, 8'h00, 16'h0);                // R3 enable
    run_cmd(3'd1, 8'h35, 16'hA5C3);             // R2 write, R7 poll
    chk(!r_tout && r_cyc >= busy_until, "R7 done after ready", 32'(r_cyc), 32'(busy_until));
    run_cmd(3'd0, 8'h35, 16'h0);
    chk(r_data == 16'hA5C3, "R6 read word", 32'(r_data), 32'hA5C3);
    run_cmd(3'd1, 8'h80, 16'h8001);
    run_cmd(3'd0, 8'h80, 16'h0);
    chk(r_data == 16'h8001, "R6 dummy dropped", 32'(r_data), 32'h8001);
    run_cmd(3'd2, 8'h35, 16'h0);                // R2 erase
    chk(!r_tout && r_cyc >= busy_until, "R7 erase poll", 32'(r_cyc), 32'(busy_until));
    run_cmd(3'd0, 8'h35, 16'h0);
    chk(r_data == 16'hFFFF, "R2 erased word", 32'(r_data), 32'hFFFF);
    run_cmd(3'd4, 8'h00, 16'h1234);             // R3 write all
    run_cmd(3'd0, 8'h07, 16'h0);
    chk(r_data == 16'h1234, "R3 write all", 32'(r_data), 32'h1234);
    run_cmd(3'd3, 8'h00, 16'h0);                // R3 erase all
    run_cmd(3'd0, 8'h80, 16'h0);
    chk(r_data == 16'hFFFF, "R3 erase all", 32'(r_data), 32'hFFFF);

    // R11: code 7 ignored
    @(negedge clk);
    cmd_op = 3'd7; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (mw_cs) seen = 1; end
      chk(!seen, "R11 null op", 32'(seen), 32'h0);
    end

    // R10: strobe during a read is ignored
    run_cmd(3'd1, 8'h22, 16'h0F0F);
    exp_q.push_back(want(3'd0, 8'h22, 16'h0));
    @(negedge clk);
    cmd_op = 3'd0; cmd_addr = 8'h22; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (30) @(negedge clk);
    cmd_op = 3'd6; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_op = 3'd0;
    wait_done();
    repeat (CS_LO + 3) @(negedge clk);
    chk(r_data == 16'h0F0F, "R10 read unaffected", 32'(r_data), 32'h0F0F);

    // R9: device never turns ready
    stuck = 1;
    run_cmd(3'd2, 8'h22, 16'h0);
    chk(r_tout, "R9 timeout raised", 32'(r_tout), 32'h1);
    chk(cmd_timeout, "R9 timeout held", 32'(cmd_timeout), 32'h1);
    stuck = 0;
    run_cmd(3'd0, 8'h22, 16'h0);
    chk(!r_tout, "R9 timeout cleared", 32'(r_tout), 32'h0);
    chk(r_data == 16'hFFFF, "R9 erase landed", 32'(r_data), 32'hFFFF);

    run_cmd(3'd6, 8'h00, 16'h0);                // R3 disable
    chk(exp_q.size() == 0, "R10 frames consumed", 32'(exp_q.size()), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule